// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five localities owns a shared, memory-mapped register interface at any moment. Each locality sees its own 4 KiB page of the address space: address bits [14:12] select the locality, and offset 0 of each page holds that locality's byte-wide access register. Software in a locality asks for ownership, gives it up, or takes it from a lower-numbered owner by writing flag bits to this register. The arbiter keeps the per-locality flags, computes the read value, and drives the current owner index (or a no-owner code) to the rest of the interface.

Ownership changes in two ways. The owner may release it, and then the highest-numbered waiting requester takes over. A higher-numbered locality may seize it, and then the displaced owner is left with a sticky flag that records the loss. When a handover is due while the command engine reports a command in flight, the arbiter raises an abort request and holds the old owner in place until the engine acknowledges. Every change of owner produces a one-cycle pulse.

Top module: `loc_arbiter`

## Requirements
- R1: The access register sits at offset 0 of each locality page. Its read layout is bit 0 request-use, bit 1 pending-request, bit 3 been-seized, bit 4 active, bit 7 register-valid (always 1), with all other bits 0; bit 2 is the write-only seize bit. After reset there is no owner (owner code 7), no flag is set, a read returns 0x80, and abort request and change pulse are low.
- R2: A request-use write while no locality owns the interface grants ownership to the writer at the next clock edge, and the change pulse is high for exactly that one cycle.
- R3: A request-use write from a non-owner while another locality owns the interface only sets the writer's request-use bit. Pending-request reads 1 for a locality exactly when some other locality has request-use set.
- R4: When the owner writes the active bit and at least one locality has request-use set, ownership moves to the highest-numbered requester, whose request-use bit is cleared.
- R5: When the owner writes the active bit and no locality has request-use set, the interface becomes unowned and the change pulse fires.
- R6: An active-bit write from a non-owner clears only that locality's own request-use bit and leaves the owner unchanged.
- R7: A seize write is honoured when there is no owner or the writer is numbered above the owner; a displaced owner gets its been-seized bit set.
- R8: A seize write from a locality numbered at or below the owner is refused and changes nothing.
- R9: Writing the been-seized bit clears it.
- R10: The seize bit never reads back as 1, including while a seize is waiting on an abort.
- R11: Writes to locality 4 are ignored, and accesses that decode to locality 5, 6 or 7 have no effect and read as 0x00.
- R12: When a handover is due while an owner exists and a command is in flight, abort request rises, the owner stays unchanged and access writes are ignored until abort acknowledge; the grant then happens at the acknowledging edge.
- R13: A write carrying the seize bit drops the request-use and active bits of the same write, so an owner writing seize plus active keeps ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 15 | Access address; bits [14:12] select the locality |
| wr_en | input | 1 | Byte write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the address of the previous cycle |
| cmd_busy | input | 1 | Command engine has a command in flight |
| abort_ack | input | 1 | Command engine has finished the requested abort |
| abort_req | output | 1 | Abort request, held until acknowledged |
| owner | output | 3 | Current owner locality, 7 when unowned |
| owner_changed | output | 1 | One-cycle pulse on each change of owner |

## Verification
Ownership is walked through a chain of requests and releases in which several localities wait at once, so that picking the highest requester is told apart from picking the first or most recent one. Seize attempts are made from below, from above and with no owner, which separates the priority rule from a plain first-come grant. The same release and seize are repeated with a command in flight, which distinguishes an immediate grant from one deferred by the abort handshake, and reads of the displaced owner show whether the been-seized flag follows a seize but not a release.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int B_REQ   = 0;
  localparam int B_PEND  = 1;
  localparam int B_SEIZE = 2;
  localparam int B_LOST  = 3;
  localparam int B_ACT   = 4;
  localparam int B_VALID = 7;
endpackage

// File: rtl/loc_addr_decode.sv
module loc_addr_decode #(
  parameter int ADDR_W  = 15,
  parameter int LOC_LSB = 12,
  parameter int LOC_W   = 3,
  parameter int REG_OFS = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LOC_W-1:0]  loc,
  output logic              reg_hit
);
  assign loc     = addr[LOC_LSB +: LOC_W];
  assign reg_hit = (addr[LOC_LSB-1:0] == LOC_LSB'(REG_OFS));
endmodule

// File: rtl/loc_top_pick.sv
module loc_top_pick #(
  parameter int N   = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/loc_read_mux.sv
module loc_read_mux #(
  parameter int N     = 5,
  parameter int LOC_W = 3
) (
  input  logic [LOC_W-1:0] rloc,
  input  logic             reg_hit,
  input  logic [N-1:0]     req,
  input  logic [N-1:0]     lost,
  input  logic [LOC_W-1:0] owner,
  output logic [7:0]       data
);
  import loc_arb_pkg::*;
  localparam logic [LOC_W-1:0] NUM_L = LOC_W'(N);

  always_comb begin
    data = 8'h00;
    if (reg_hit && rloc < NUM_L) begin
      data[B_VALID] = 1'b1;
      data[B_REQ]   = req[rloc];
      data[B_LOST]  = lost[rloc];
      data[B_ACT]   = (owner == rloc);
      for (int i = 0; i < N; i++)
        if (LOC_W'(i) != rloc && req[i]) data[B_PEND] = 1'b1;
    end
  end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter #(
  parameter int ADDR_W  = 15,
  parameter int LOC_LSB = 12,
  parameter int LOC_W   = 3,
  parameter int NUM_LOC = 5,
  parameter int MUTE_LOC = 4,
  parameter int REG_OFS = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              cmd_busy,
  input  logic              abort_ack,
  output logic              abort_req,
  output logic [LOC_W-1:0]  owner,
  output logic              owner_changed
);
  import loc_arb_pkg::*;
  localparam logic [LOC_W-1:0] NUM_L  = LOC_W'(NUM_LOC);
  localparam logic [LOC_W-1:0] MUTE_L = LOC_W'(MUTE_LOC);
  localparam logic [LOC_W-1:0] NONE   = '1;

  logic [NUM_LOC-1:0] req_q, sz_q, lost_q;
  logic [NUM_LOC-1:0] n_req, n_sz, n_lost;
  logic [LOC_W-1:0]   owner_q, n_owner, pend_tgt_q, tgt, g_tgt;
  logic               pend_q, chg_q;
  logic [LOC_W-1:0]   wloc;
  logic               reg_hit;
  logic               pick_any;
  logic [LOC_W-1:0]   pick_idx;
  logic [7:0]         rd_comb, v;
  logic               own_vld, is_owner, wr_ok;
  logic               start_ho, rel_none, hi_sz, need_abort, do_grant;

  loc_addr_decode #(.ADDR_W(ADDR_W), .LOC_LSB(LOC_LSB), .LOC_W(LOC_W), .REG_OFS(REG_OFS))
    u_dec (.addr(bus_addr), .loc(wloc), .reg_hit(reg_hit));

  loc_top_pick #(.N(NUM_LOC), .IDX_W(LOC_W))
    u_pick (.req(req_q), .any(pick_any), .idx(pick_idx));

  loc_read_mux #(.N(NUM_LOC), .LOC_W(LOC_W))
    u_rmux (.rloc(wloc), .reg_hit(reg_hit), .req(req_q), .lost(lost_q),
            .owner(owner_q), .data(rd_comb));

  assign own_vld  = (owner_q < NUM_L);
  assign is_owner = own_vld && (owner_q == wloc);
  assign wr_ok    = wr_en && reg_hit && (wloc < NUM_L) && (wloc != MUTE_L) && !pend_q;

  always_comb begin
    n_req    = req_q;
    n_sz     = sz_q;
    n_lost   = lost_q;
    n_owner  = owner_q;
    v        = wr_data;
    start_ho = 1'b0;
    rel_none = 1'b0;
    hi_sz    = 1'b0;
    tgt      = owner_q;
    if (wr_ok) begin
      if (v[B_SEIZE]) begin
        v[B_REQ] = 1'b0;
        v[B_ACT] = 1'b0;
      end
      if (v[B_ACT]) begin
        if (is_owner) begin
          if (pick_any) begin
            start_ho = 1'b1;
            tgt      = pick_idx;
          end else begin
            rel_none = 1'b1;
          end
        end else begin
          n_req[wloc] = 1'b0;
        end
      end
      if (v[B_LOST]) n_lost[wloc] = 1'b0;
      if (v[B_SEIZE]) begin
        for (int i = 0; i < NUM_LOC; i++)
          if (LOC_W'(i) > wloc && sz_q[i]) hi_sz = 1'b1;
        if ((!own_vld || wloc > owner_q) && !sz_q[wloc] && !hi_sz) begin
          for (int i = 0; i < NUM_LOC; i++)
            if (LOC_W'(i) < wloc) n_sz[i] = 1'b0;
          n_sz[wloc] = 1'b1;
          start_ho   = 1'b1;
          tgt        = wloc;
        end
      end
      if (v[B_REQ] && !is_owner) begin
        if (own_vld) begin
          n_req[wloc] = 1'b1;
        end else begin
          start_ho = 1'b1;
          tgt      = wloc;
        end
      end
    end
    need_abort = start_ho && own_vld && cmd_busy;
    do_grant   = (start_ho && !need_abort) || (pend_q && abort_ack);
    g_tgt      = pend_q ? pend_tgt_q : tgt;
    if (do_grant) begin
      if (own_vld && owner_q != g_tgt) begin
        if (n_sz[g_tgt]) n_lost[owner_q] = 1'b1;
        else             n_req[owner_q]  = 1'b0;
      end
      n_req[g_tgt] = 1'b0;
      n_sz[g_tgt]  = 1'b0;
      n_owner      = g_tgt;
    end else if (rel_none) begin
      n_owner = NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= '0;
      sz_q       <= '0;
      lost_q     <= '0;
      owner_q    <= NONE;
      pend_q     <= 1'b0;
      pend_tgt_q <= NONE;
      chg_q      <= 1'b0;
      rd_data    <= 8'h00;
    end else begin
      req_q   <= n_req;
      sz_q    <= n_sz;
      lost_q  <= n_lost;
      owner_q <= n_owner;
      chg_q   <= (n_owner != owner_q);
      rd_data <= rd_comb;
      if (need_abort) begin
        pend_q     <= 1'b1;
        pend_tgt_q <= tgt;
      end else if (pend_q && abort_ack) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign owner         = owner_q;
  assign owner_changed = chg_q;
  assign abort_req     = pend_q;

  a_r1_owner_code: assert property (@(posedge clk) disable iff (rst)
    own_vld || owner_q == NONE);
  a_r2_change_pulse: assert property (@(posedge clk) disable iff (rst)
    (owner_q != $past(owner_q)) |-> owner_changed);
  a_r4_owner_no_req: assert property (@(posedge clk) disable iff (rst)
    own_vld |-> !req_q[owner_q]);
  a_r10_one_seize: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sz_q));
  a_r11_mute_never_owns: assert property (@(posedge clk) disable iff (rst)
    owner_q != MUTE_L);
  a_r12_hold_owner: assert property (@(posedge clk) disable iff (rst)
    (abort_req && !abort_ack) |=> ($stable(owner_q) && abort_req));
endmodule

// File: tb/loc_arbiter_bench.sv
`timescale 1ns/1ps
module loc_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        cmd_busy = 1'b0;
  logic        abort_ack = 1'b0;
  logic        abort_req;
  logic [2:0]  owner;
  logic        owner_changed;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  loc_arbiter u_loc_arbiter (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cmd_busy(cmd_busy), .abort_ack(abort_ack),
    .abort_req(abort_req), .owner(owner), .owner_changed(owner_changed)
  );

  // row = {locality[2:0], write data[7:0], expected owner[2:0]}
  localparam int ROWS = 13;
  localparam logic [13:0] TBL [ROWS] = '{
    {3'd1, 8'h01, 3'd1},  // R2 grant with no owner
    {3'd3, 8'h01, 3'd1},  // R3 queue request
    {3'd2, 8'h01, 3'd1},  // R3 queue request
    {3'd1, 8'h10, 3'd3},  // R4 release to highest requester
    {3'd0, 8'h01, 3'd3},  // R3
    {3'd3, 8'h10, 3'd2},  // R4
    {3'd2, 8'h10, 3'd0},  // R4
    {3'd0, 8'h10, 3'd7},  // R5 release, nobody waiting
    {3'd2, 8'h04, 3'd2},  // R7 seize with no owner
    {3'd1, 8'h04, 3'd2},  // R8 lower seize refused
    {3'd3, 8'h04, 3'd3},  // R7 higher seize
    {3'd4, 8'h01, 3'd3},  // R11 locality 4 muted
    {3'd5, 8'h01, 3'd3}   // R11 out-of-range locality
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] loc, input logic [7:0] d);
    @(negedge clk);
    bus_addr = {loc, 12'h000};
    wr_data  = d;
    wr_en    = 1'b1;
    @(negedge clk);
    wr_en    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] loc, output logic [7:0] d);
    @(negedge clk);
    bus_addr = {loc, 12'h000};
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic ack();
    @(negedge clk);
    abort_ack = 1'b1;
    @(negedge clk);
    abort_ack = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd0, r);
    chk("R1 read after reset", r, 8'h80);
    chk("R1 owner after reset", {5'd0, owner}, 8'h07);
    chk("R1 abort after reset", {7'd0, abort_req}, 8'h00);
    chk("R1 pulse after reset", {7'd0, owner_changed}, 8'h00);

    for (int i = 0; i < ROWS; i++) begin
      wr(TBL[i][13:11], TBL[i][10:3]);
      chk($sformatf("owner table row %0d (R2 R4 R5 R7 R8 R11)", i),
          {5'd0, owner}, {5'd0, TBL[i][2:0]});
    end

    rd(3'd2, r);
    chk("R7 displaced owner flag", r, 8'h88);
    wr(3'd2, 8'h08);
    rd(3'd2, r);
    chk("R9 clear flag", r, 8'h80);

    wr(3'd1, 8'h01);
    rd(3'd3, r);
    chk("R3 pending seen by owner", r, 8'h92);
    rd(3'd1, r);
    chk("R3 own request, no pending", r, 8'h81);
    wr(3'd1, 8'h10);
    rd(3'd1, r);
    chk("R6 non-owner drop request", r, 8'h80);
    chk("R6 owner kept", {5'd0, owner}, 8'h03);

    wr(3'd3, 8'h14);
    chk("R13 seize plus active keeps owner", {5'd0, owner}, 8'h03);

    // R12 deferred release
    cmd_busy = 1'b1;
    wr(3'd0, 8'h01);
    wr(3'd3, 8'h10);
    chk("R12 abort raised", {7'd0, abort_req}, 8'h01);
    chk("R12 owner held", {5'd0, owner}, 8'h03);
    wr(3'd2, 8'h01);
    rd(3'd2, r);
    chk("R12 write ignored while waiting", r, 8'h82);
    ack();
    chk("R12 grant at ack", {5'd0, owner}, 8'h00);
    chk("R12 abort dropped", {7'd0, abort_req}, 8'h00);

    // R10 seize waiting on abort
    wr(3'd2, 8'h04);
    chk("R10 seize deferred", {7'd0, abort_req}, 8'h01);
    rd(3'd2, r);
    chk("R10 seize bit hidden", r, 8'h80);
    ack();
    chk("R7 deferred seize owner", {5'd0, owner}, 8'h02);
    rd(3'd0, r);
    chk("R7 seized flag after deferred seize", r, 8'h88);
    cmd_busy = 1'b0;

    wr(3'd2, 8'h10);
    chk("R5 owner none", {5'd0, owner}, 8'h07);
    chk("R5 pulse", {7'd0, owner_changed}, 8'h01);

    wr(3'd4, 8'h01);
    chk("R11 locality 4 request ignored", {5'd0, owner}, 8'h07);
    rd(3'd5, r);
    chk("R11 out-of-range read", r, 8'h00);
    rd(3'd4, r);
    chk("R11 locality 4 readable", r, 8'h80);

    wr(3'd0, 8'h01);
    chk("R2 grant", {5'd0, owner}, 8'h00);
    chk("R2 pulse high", {7'd0, owner_changed}, 8'h01);
    @(negedge clk);
    chk("R2 pulse one cycle", {7'd0, owner_changed}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule